// File: doc/BRIEF.md
# Map-Gated Sparse MAC Engine

This engine produces one convolution output from a small filter window and skips work at two levels. A single output-enable bit comes with each job. When that bit is clear, the engine fetches nothing and reports a zero result. When the bit is set, the engine walks a per-tap input mask and fetches an activation and weight pair only for the taps whose mask bit is one. It then multiplies and accumulates each pair into a wrapping accumulator.

After the last tap, a rectifier stage corrects the prediction. A result that is not strictly positive is reported as zero, and its output-enable bit is returned cleared. The returned bit becomes part of the next layer's input mask, so each correction adds sparsity downstream. Operands come through a simple request/response port that allows one outstanding request and any response delay. A skipped output still completes with a zero write, so the caller can keep output addressing dense.

Top module: `mge_sparse_mac`

## Requirements
- R1: After reset, `done`, `mem_req`, `result`, `omap_out` and `mac_count` are all zero until the first accepted `start`.
- R2: A job started with `omap_in` = 0 issues no operand request. It completes with `result` = 0, `omap_out` = 0 and `mac_count` = 0.
- R3: With `omap_in` = 1, a request is issued exactly once for each tap whose bit in `imap_in` is 1, and for no other tap. Requests go in ascending tap index. Tap index is (channel·KH + row)·KW + column, and bit i of `imap_in` belongs to tap i.
- R4: When a computed job finishes, `mac_count` equals the number of ones in `imap_in`. A fully dense 3×3×3 window gives 27.
- R5: The accumulator sums act·wgt over the fetched taps in 32-bit two's complement with wraparound and no saturation. `result` is that sum when it is greater than zero, and 0 otherwise.
- R6: `omap_out` is 1 only when `omap_in` was 1 and the wrapped sum is greater than zero. A predicted output that ends non-positive comes back with its bit cleared.
- R7: At most one request is outstanding. `mem_req` stays low from a request until the cycle after its `mem_rsp_valid`, whatever the response delay.
- R8: `done` is high for exactly one cycle per job. A `start` that arrives while a job is running is ignored and does not change that job's outputs.
- R9: `result`, `omap_out` and `mac_count` hold steady from `done` until the next accepted `start`.
- R10: A computed job with an all-zero `imap_in` issues no request and finishes with `result` = 0, `mac_count` = 0 and `omap_out` cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job; sampled only while idle |
| omap_in | input | 1 | Predicted-effectual bit of the output neuron |
| imap_in | input | TAPS | Per-tap input effectual mask, bit i = tap i |
| mem_req | output | 1 | One-cycle operand request |
| mem_tap | output | TW | Tap index of the request |
| mem_rsp_valid | input | 1 | Operand response valid |
| mem_act | input | DW | Signed activation of the requested tap |
| mem_wgt | input | DW | Signed weight of the requested tap |
| done | output | 1 | One-cycle job completion pulse |
| result | output | AW | Rectified accumulated value |
| omap_out | output | 1 | Corrected output-enable bit for write-back |
| mac_count | output | CNTW | MACs issued for the last job |

## Verification
The assertions assume that `mem_rsp_valid` comes only once per request, while the engine waits for it, and that the operands are valid in that same cycle. The bench answers each request exactly once, with a delay of one to three cycles. The properties do not depend on the response delay. A `start` during a running job is presented only in the one directed test built to show that it is ignored, so in all other runs the job inputs are changed only while the engine is idle.

// File: rtl/mge_pkg.sv
package mge_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } eng_state_e;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/mge_tap_pick.sv
module mge_tap_pick #(
  parameter int TAPS = 27,
  parameter int TW   = 5
) (
  input  logic [TAPS-1:0] mask,
  output logic            found,
  output logic [TW-1:0]   idx
);

  // lowest set bit wins, giving ascending fetch order
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = TAPS - 1; i >= 0; i--) begin
      if (mask[i]) begin
        found = 1'b1;
        idx   = TW'(i);
      end
    end
  end

endmodule

// File: rtl/mge_accum.sv
module mge_accum #(
  parameter int DW   = 16,
  parameter int AW   = 32,
  parameter int CNTW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] w,
  output logic signed [AW-1:0] acc,
  output logic [CNTW-1:0]      cnt
);

  function automatic logic signed [AW-1:0] mac_step(
    input logic signed [AW-1:0] sum,
    input logic signed [DW-1:0] x,
    input logic signed [DW-1:0] y
  );
    logic signed [2*DW-1:0] prod;
    prod = x * y;
    return sum + AW'(prod);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      cnt <= '0;
    end else if (clr) begin
      acc <= '0;
      cnt <= '0;
    end else if (en) begin
      acc <= mac_step(acc, a, w);
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/mge_relu_fix.sv
module mge_relu_fix #(
  parameter int AW = 32
) (
  input  logic signed [AW-1:0] sum,
  input  logic                 predicted,
  output logic [AW-1:0]        value,
  output logic                 keep
);

  function automatic logic is_positive(input logic signed [AW-1:0] x);
    return x > 0;
  endfunction

  always_comb begin
    value = is_positive(sum) ? sum : '0;
    keep  = predicted & is_positive(sum);
  end

endmodule

// File: rtl/mge_sparse_mac.sv
module mge_sparse_mac #(
  parameter int KH   = 3,
  parameter int KW   = 3,
  parameter int CH   = 3,
  parameter int DW   = 16,
  parameter int AW   = 32,
  localparam int TAPS = KH * KW * CH,
  localparam int TW   = mge_pkg::idx_bits(TAPS),
  localparam int CNTW = mge_pkg::idx_bits(TAPS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 omap_in,
  input  logic [TAPS-1:0]      imap_in,
  output logic                 mem_req,
  output logic [TW-1:0]        mem_tap,
  input  logic                 mem_rsp_valid,
  input  logic signed [DW-1:0] mem_act,
  input  logic signed [DW-1:0] mem_wgt,
  output logic                 done,
  output logic [AW-1:0]        result,
  output logic                 omap_out,
  output logic [CNTW-1:0]      mac_count
);
  import mge_pkg::*;

  eng_state_e          state;
  logic                omap_q;
  logic [TAPS-1:0]     imap_q;
  logic [TAPS-1:0]     pending;
  logic                pick_found;
  logic [TW-1:0]       pick_idx;
  logic signed [AW-1:0] acc;

  // named events for the checker
  logic busy, waiting, accept, mac_fire;
  assign busy     = (state != ST_IDLE);
  assign waiting  = (state == ST_WAIT);
  assign accept   = (state == ST_IDLE) && start;
  assign mac_fire = waiting && mem_rsp_valid;

  mge_tap_pick #(.TAPS(TAPS), .TW(TW)) u_pick (
    .mask  (pending),
    .found (pick_found),
    .idx   (pick_idx)
  );

  mge_accum #(.DW(DW), .AW(AW), .CNTW(CNTW)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .en    (mac_fire),
    .a     (mem_act),
    .w     (mem_wgt),
    .acc   (acc),
    .cnt   (mac_count)
  );

  mge_relu_fix #(.AW(AW)) u_fix (
    .sum       (acc),
    .predicted (omap_q),
    .value     (result),
    .keep      (omap_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      omap_q  <= 1'b0;
      imap_q  <= '0;
      pending <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          omap_q  <= omap_in;
          imap_q  <= imap_in;
          pending <= omap_in ? imap_in : '0;
          state   <= ST_ISSUE;
        end
        ST_ISSUE: if (pick_found) begin
          pending[pick_idx] <= 1'b0;
          state             <= ST_WAIT;
        end else begin
          state <= ST_DONE;
        end
        ST_WAIT: if (mem_rsp_valid) state <= ST_ISSUE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req = (state == ST_ISSUE) && pick_found;
  assign mem_tap = pick_idx;
  assign done    = (state == ST_DONE);

endmodule

// File: rtl/mge_sparse_mac_chk.sv
module mge_sparse_mac_chk #(
  parameter int TAPS = 27,
  parameter int TW   = 5,
  parameter int AW   = 32,
  parameter int CNTW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            waiting,
  input logic            omap_q,
  input logic [TAPS-1:0] imap_q,
  input logic            mem_req,
  input logic [TW-1:0]   mem_tap,
  input logic            done,
  input logic [AW-1:0]   result,
  input logic            omap_out,
  input logic [CNTW-1:0] mac_count
);

  a_r2_no_fetch_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !omap_q) |-> !mem_req);

  a_r2_zero_count_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !omap_q) |-> (mac_count == '0) && (result == '0));

  a_r3_tap_in_map: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> imap_q[mem_tap]);

  a_r4_count_matches_map: assert property (@(posedge clk) disable iff (!rst_n)
    (done && omap_q) |-> (mac_count == CNTW'($countones(imap_q))));

  a_r6_bit_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !omap_q) |-> !omap_out);

  a_r7_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !mem_req);

  a_r7_req_then_wait: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> waiting);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(result) && $stable(omap_out) && $stable(mac_count)));

endmodule

bind mge_sparse_mac mge_sparse_mac_chk #(
  .TAPS(TAPS), .TW(TW), .AW(AW), .CNTW(CNTW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .waiting   (waiting),
  .omap_q    (omap_q),
  .imap_q    (imap_q),
  .mem_req   (mem_req),
  .mem_tap   (mem_tap),
  .done      (done),
  .result    (result),
  .omap_out  (omap_out),
  .mac_count (mac_count)
);

// File: tb/mge_sparse_mac_tb_top.sv
`timescale 1ns/1ps
module mge_sparse_mac_tb_top;

  localparam int TAPS = 27;
  localparam int TW   = 5;
  localparam int CNTW = 5;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   start = 1'b0;
  logic                   omap_in = 1'b0;
  logic [TAPS-1:0]        imap_in = '0;
  logic                   mem_req;
  logic [TW-1:0]          mem_tap;
  logic                   mem_rsp_valid = 1'b0;
  logic signed [15:0]     mem_act = '0;
  logic signed [15:0]     mem_wgt = '0;
  logic                   done;
  logic [31:0]            result;
  logic                   omap_out;
  logic [CNTW-1:0]        mac_count;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  mge_sparse_mac dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .omap_in(omap_in), .imap_in(imap_in),
    .mem_req(mem_req), .mem_tap(mem_tap), .mem_rsp_valid(mem_rsp_valid),
    .mem_act(mem_act), .mem_wgt(mem_wgt), .done(done), .result(result),
    .omap_out(omap_out), .mac_count(mac_count)
  );

  typedef struct packed {
    logic            omap;
    logic [TAPS-1:0] imap;
    logic [7:0]      seed;
    logic [3:0]      lat;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 27'h7FFFFFF, 8'd1,  4'd1},
    '{1'b0, 27'h7FFFFFF, 8'd2,  4'd1},
    '{1'b1, 27'h0000155, 8'd3,  4'd2},
    '{1'b1, 27'h4000001, 8'd4,  4'd3},
    '{1'b1, 27'h0000000, 8'd5,  4'd1},
    '{1'b1, 27'h000000F, 8'd99, 4'd1},
    '{1'b1, 27'h00001FF, 8'd98, 4'd2},
    '{1'b1, 27'h5A5A5A5, 8'd7,  4'd2},
    '{1'b1, 27'h0F0F0F0, 8'd97, 4'd1}
  };

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int act_of(input int seed, input int tap);
    case (seed)
      99: return 32767;
      98: return -32768;
      97: return tap + 1;
      default: return ((tap * 73 + seed * 29) % 401) - 200;
    endcase
  endfunction

  function automatic int wgt_of(input int seed, input int tap);
    case (seed)
      99, 98: return 32767;
      97: return 2;
      default: return ((tap * 41 + seed * 53) % 301) - 150;
    endcase
  endfunction

  function automatic int next_set(input logic [TAPS-1:0] m, input int from);
    for (int i = from; i < TAPS; i++) if (m[i]) return i;
    return -1;
  endfunction

  // runs one job; optionally pokes a start while busy
  task automatic run_job(input logic om, input logic [TAPS-1:0] im, input int seed,
                         input int lat, input bit poke, input string tag);
    int sum = 0;
    int prev = -1;
    int bad_order = 0;
    int overlap = 0;
    int cnt_exp;
    bit seen = 0;
    bit poked = 0;
    @(negedge clk);
    omap_in = om; imap_in = im; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 600 && !seen; cyc++) begin
      if (mem_req) begin
        int t = int'(mem_tap);
        int e = om ? next_set(im, prev + 1) : -1;
        if (t != e) bad_order++;
        prev = t;
        sum = sum + act_of(seed, t) * wgt_of(seed, t);
        @(negedge clk);
        if (poke && !poked) begin
          start = 1'b1; omap_in = 1'b0; imap_in = '0;
          poked = 1;
        end
        for (int k = 1; k < lat; k++) begin
          if (mem_req) overlap++;
          @(negedge clk);
          start = 1'b0;
        end
        start = 1'b0;
        if (mem_req) overlap++;
        mem_rsp_valid = 1'b1;
        mem_act = 16'(act_of(seed, t));
        mem_wgt = 16'(wgt_of(seed, t));
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_act = '0; mem_wgt = '0;
      end else if (done) begin
        seen = 1;
      end else begin
        @(negedge clk);
      end
    end
    cnt_exp = om ? $countones(im) : 0;
    check({"R8 done seen ", tag}, seen, 1);
    if (om) check({"R3 fetch order ", tag}, bad_order, 0);
    else    check({"R2 no fetch when off ", tag}, prev, -1);
    if (om) check({"R3 no missed tap ", tag}, next_set(im, prev + 1), -1);
    check({"R7 single outstanding ", tag}, overlap, 0);
    check({"R4 mac count ", tag}, mac_count, cnt_exp);
    check({"R5 result ", tag}, result, (om && sum > 0) ? longint'(unsigned'(sum)) : 0);
    check({"R6 corrected bit ", tag}, omap_out, (om && sum > 0) ? 1 : 0);
    @(negedge clk);
    check({"R8 done one cycle ", tag}, done, 0);
    @(negedge clk);
    @(negedge clk);
    check({"R9 result held ", tag}, result, (om && sum > 0) ? longint'(unsigned'(sum)) : 0);
    check({"R9 count held ", tag}, mac_count, cnt_exp);
    check({"R9 bit held ", tag}, omap_out, (om && sum > 0) ? 1 : 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 done", done, 0);
    check("R1 mem_req", mem_req, 0);
    check("R1 result", result, 0);
    check("R1 omap_out", omap_out, 0);
    check("R1 mac_count", mac_count, 0);

    // vector walk (R2..R7, R9, R10)
    for (int v = 0; v < NV; v++) begin
      run_job(VECS[v].omap, VECS[v].imap, int'(VECS[v].seed), int'(VECS[v].lat),
              1'b0, $sformatf("vec%0d", v));
    end

    // R10 explicit empty mask with output predicted on
    run_job(1'b1, '0, 11, 1, 1'b0, "R10 empty mask");

    // R8 start ignored while busy: job outputs must reflect the first job
    run_job(1'b1, 27'h0000F0F, 97, 3, 1'b1, "R8 busy start");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule